// File: doc/BRIEF.md
# Instruction Fetch Guard

This block sits between the memory read-data return path and the CPU. It looks at every bus cycle and decides whether the cycle is an instruction fetch from a forbidden address range. When it is, the block replaces the word handed back to the CPU with an all-zero word. That encoding is illegal, so the CPU traps. Data reads and writes, and cycles with no valid request, get the memory word unchanged.

Two ranges are forbidden. The first is a fixed 2 KiB window that holds the firmware-only scratch RAM. Fetches from it are refused whatever software has configured. The second is a window that software sets up through a lower-bound register, an upper-bound register and an arm register. Once the window is armed it stays armed, and its bounds can no longer be changed.

Each refused fetch also sets a violation flag. The flag stays set until reset. Trap handling inside the CPU belongs to the CPU, not to this block.

Top module: `fetch_guard`

## Requirements
- R1: After reset, `violation` is 0, the software window is disarmed and both bounds are 0, so a fetch outside the fixed window returns `mem_rdata` unchanged.
- R2: A valid fetch (`bus_valid`=1, `bus_fetch`=1) to any byte address from 0xD000_0000 to 0xD000_07FF inclusive returns 32'h0000_0000 on `cpu_rdata` in the same cycle, whatever the software window configuration.
- R3: A valid fetch to 0xCFFF_FFFC or to 0xD000_0800 (the words just outside the fixed window) returns `mem_rdata` unchanged when the software window does not cover it.
- R4: A valid data access (`bus_fetch`=0) returns `mem_rdata` unchanged at every address, including addresses inside both windows.
- R5: A cycle with `bus_valid`=0 returns `mem_rdata` unchanged and never sets `violation`.
- R6: While armed, the software window refuses valid fetches with lower <= address <= upper, both bounds included. Fetches at lower-4 and upper+4 pass.
- R7: While the window is disarmed, the programmed bounds have no effect on any fetch.
- R8: A write to the arm register (`wr_arm`) with `cfg_wdata` bit 0 = 1 arms the window. A write with bit 0 = 0 leaves the arm state unchanged.
- R9: Once the window is armed, writes to either bound register and arm writes with bit 0 = 0 are ignored, so the refused range stays the same.
- R10: `violation` goes to 1 at the clock edge that ends a refused fetch and stays at 1 until reset.
- R11: An armed window whose lower bound is greater than its upper bound refuses no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus request is present this cycle |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_addr | input | 32 | Byte address of the request |
| mem_rdata | input | 32 | Word returned by the memory system |
| cfg_wdata | input | 32 | Write data for the configuration registers |
| wr_lower | input | 1 | Write strobe for the window lower bound |
| wr_upper | input | 1 | Write strobe for the window upper bound |
| wr_arm | input | 1 | Write strobe for the arm register (bit 0 arms) |
| cpu_rdata | output | 32 | Word passed to the CPU, replaced on a refused fetch |
| violation | output | 1 | Sticky flag: a refused fetch has occurred |

## Verification
The bench sweeps fetch addresses word by word across both edges of each window.
- A design with an off-by-one or exclusive compare would pass the first or last word of a window, or refuse the word just beyond it.
- A guard that ignores the fetch indicator would corrupt data reads.
- A guard that keeps obeying writes after arming would move or shrink the software window after a second round of bound writes.
- An inverted or swapped window, with lower above upper, is also swept: a magnitude check that wraps around would refuse addresses there.
- The violation flag is checked after every access, so a flag that clears by itself or rises on an invalid cycle shows up at once.

// File: rtl/fetch_guard_pkg.sv
package fetch_guard_pkg;

   localparam int unsigned FG_AW = 32;
   localparam int unsigned FG_DW = 32;

   typedef enum logic {
      RGN_FIXED = 1'b0,
      RGN_SOFT  = 1'b1
   } fg_region_e;

   localparam int unsigned FG_NUM_RGN = 2;

   function automatic bit fg_is_pow2(input longint unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fg_range_cmp.sv
module fg_range_cmp #(
   parameter int unsigned AW = 32
) (
   input  logic          enable,
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] lower,
   input  logic [AW-1:0] upper,
   output logic          hit
);
   // inclusive on both bounds; an inverted window never matches
   always_comb begin
      hit = enable && (addr >= lower) && (addr <= upper);
   end
endmodule

// File: rtl/fg_prefix_cmp.sv
module fg_prefix_cmp #(
   parameter int unsigned   AW        = 32,
   parameter int unsigned   SPAN_LOG2 = 11,
   parameter logic [AW-1:0] BASE      = '0
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   localparam int unsigned TAG_W = AW - SPAN_LOG2;
   localparam logic [TAG_W-1:0] BASE_TAG = BASE[AW-1:SPAN_LOG2];

   always_comb begin
      hit = (addr[AW-1:SPAN_LOG2] == BASE_TAG);
   end
endmodule

// File: rtl/fg_soft_window.sv
module fg_soft_window #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cfg_wdata,
   input  logic          wr_lower,
   input  logic          wr_upper,
   input  logic          wr_arm,
   output logic [AW-1:0] lower,
   output logic [AW-1:0] upper,
   output logic          armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lower <= '0;
         upper <= '0;
         armed <= 1'b0;
      end else if (!armed) begin
         if (wr_lower) lower <= cfg_wdata;
         if (wr_upper) upper <= cfg_wdata;
         if (wr_arm && cfg_wdata[0]) armed <= 1'b1;
      end
   end
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard
   import fetch_guard_pkg::*;
#(
   parameter int unsigned       ADDR_W      = FG_AW,
   parameter int unsigned       DATA_W      = FG_DW,
   parameter logic [ADDR_W-1:0] FIXED_BASE  = 32'hD000_0000,
   parameter int unsigned       FIXED_BYTES = 2048,
   parameter logic [DATA_W-1:0] TRAP_WORD   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_fetch,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              wr_lower,
   input  logic              wr_upper,
   input  logic              wr_arm,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              violation
);
   localparam int unsigned      SPAN_LOG2 = $clog2(FIXED_BYTES);
   localparam bit               FIXED_POW2 = fg_is_pow2(FIXED_BYTES);
   localparam logic [ADDR_W-1:0] FIXED_LAST = FIXED_BASE + ADDR_W'(FIXED_BYTES - 1);

   initial begin
      assert (FIXED_BYTES > 0 && SPAN_LOG2 < ADDR_W)
         else $error("fetch_guard: FIXED_BYTES out of range");
      assert (ADDR_W >= 2 && DATA_W >= 1)
         else $error("fetch_guard: bad widths");
   end

   logic [ADDR_W-1:0]     soft_lo;
   logic [ADDR_W-1:0]     soft_hi;
   logic                  soft_armed;
   logic [FG_NUM_RGN-1:0] rgn_hit;
   logic                  refuse;

   fg_soft_window #(.AW(ADDR_W)) u_soft (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wdata (cfg_wdata),
      .wr_lower  (wr_lower),
      .wr_upper  (wr_upper),
      .wr_arm    (wr_arm),
      .lower     (soft_lo),
      .upper     (soft_hi),
      .armed     (soft_armed)
   );

   generate
      if (FIXED_POW2 && ((FIXED_BASE & ADDR_W'(FIXED_BYTES - 1)) == '0)) begin : g_fixed_prefix
         fg_prefix_cmp #(
            .AW        (ADDR_W),
            .SPAN_LOG2 (SPAN_LOG2),
            .BASE      (FIXED_BASE)
         ) u_fixed (
            .addr (bus_addr),
            .hit  (rgn_hit[RGN_FIXED])
         );
      end else begin : g_fixed_range
         fg_range_cmp #(.AW(ADDR_W)) u_fixed (
            .enable (1'b1),
            .addr   (bus_addr),
            .lower  (FIXED_BASE),
            .upper  (FIXED_LAST),
            .hit    (rgn_hit[RGN_FIXED])
         );
      end
   endgenerate

   fg_range_cmp #(.AW(ADDR_W)) u_soft_cmp (
      .enable (soft_armed),
      .addr   (bus_addr),
      .lower  (soft_lo),
      .upper  (soft_hi),
      .hit    (rgn_hit[RGN_SOFT])
   );

   always_comb begin
      refuse    = bus_valid && bus_fetch && (|rgn_hit);
      cpu_rdata = refuse ? TRAP_WORD : mem_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      violation <= 1'b0;
      else if (refuse) violation <= 1'b1;
   end
endmodule

// File: rtl/fetch_guard_chk.sv
module fetch_guard_chk #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       DATA_W      = 32,
   parameter logic [ADDR_W-1:0] FIXED_BASE  = 32'hD000_0000,
   parameter int unsigned       FIXED_BYTES = 2048,
   parameter logic [DATA_W-1:0] TRAP_WORD   = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_fetch,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] cpu_rdata,
   input logic              violation,
   input logic [ADDR_W-1:0] soft_lo,
   input logic [ADDR_W-1:0] soft_hi,
   input logic              soft_armed
);
   localparam logic [ADDR_W-1:0] LAST = FIXED_BASE + ADDR_W'(FIXED_BYTES - 1);

   assert_fixed_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_fetch && bus_addr >= FIXED_BASE && bus_addr <= LAST)
      |-> (cpu_rdata == TRAP_WORD));

   assert_data_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_fetch) |-> (cpu_rdata == mem_rdata));

   assert_idle_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> (cpu_rdata == mem_rdata));

   assert_soft_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_fetch && soft_armed && bus_addr >= soft_lo && bus_addr <= soft_hi)
      |-> (cpu_rdata == TRAP_WORD));

   assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_armed |=> (soft_armed && soft_lo == $past(soft_lo) && soft_hi == $past(soft_hi)));

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);

   assert_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(violation) |-> $past(bus_valid && bus_fetch));
endmodule

bind fetch_guard fetch_guard_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .FIXED_BASE  (FIXED_BASE),
   .FIXED_BYTES (FIXED_BYTES),
   .TRAP_WORD   (TRAP_WORD)
) u_fetch_guard_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_valid  (bus_valid),
   .bus_fetch  (bus_fetch),
   .bus_addr   (bus_addr),
   .mem_rdata  (mem_rdata),
   .cpu_rdata  (cpu_rdata),
   .violation  (violation),
   .soft_lo    (soft_lo),
   .soft_hi    (soft_hi),
   .soft_armed (soft_armed)
);

// File: tb/fetch_guard_bench.sv
module fetch_guard_bench;
   localparam logic [31:0] FX_LO = 32'hD000_0000;
   localparam logic [31:0] FX_HI = 32'hD000_07FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_fetch = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] mem_rdata = '0;
   logic [31:0] cfg_wdata = '0;
   logic        wr_lower = 1'b0;
   logic        wr_upper = 1'b0;
   logic        wr_arm = 1'b0;
   logic [31:0] cpu_rdata;
   logic        violation;

   int checks = 0;
   int failures = 0;
   bit viol_m = 1'b0;
   bit en_m = 1'b0;
   logic [31:0] lo_m = '0;
   logic [31:0] hi_m = '0;

   always #4 clk = ~clk;

   fetch_guard u_fetch_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_fetch (bus_fetch),
      .bus_addr  (bus_addr),
      .mem_rdata (mem_rdata),
      .cfg_wdata (cfg_wdata),
      .wr_lower  (wr_lower),
      .wr_upper  (wr_upper),
      .wr_arm    (wr_arm),
      .cpu_rdata (cpu_rdata),
      .violation (violation)
   );

   function automatic bit in_fixed(input logic [31:0] a);
      return (a >= FX_LO) && (a <= FX_HI);
   endfunction

   function automatic bit exp_refuse(input logic [31:0] a);
      return in_fixed(a) || (en_m && (a >= lo_m) && (a <= hi_m));
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic access(input logic valid, input logic fetch,
                         input logic [31:0] a, input string req);
      logic [31:0] d;
      logic [31:0] exp;
      bit          blk;
      d   = (a ^ 32'hA5C3_0F00) | 32'h1;
      blk = valid && fetch && exp_refuse(a);
      @(negedge clk);
      bus_valid = valid;
      bus_fetch = fetch;
      bus_addr  = a;
      mem_rdata = d;
      #1;
      exp = blk ? 32'h0 : d;
      check(cpu_rdata === exp, req, cpu_rdata, exp);
      @(posedge clk);
      #1;
      if (blk) viol_m = 1'b1;
      check(violation === viol_m, "R10", {31'b0, violation}, {31'b0, viol_m});
      bus_valid = 1'b0;
      bus_fetch = 1'b0;
   endtask

   // sel: 0 lower bound, 1 upper bound, 2 arm register
   task automatic cfg_write(input int sel, input logic [31:0] v);
      @(negedge clk);
      cfg_wdata = v;
      wr_lower  = (sel == 0);
      wr_upper  = (sel == 1);
      wr_arm    = (sel == 2);
      @(negedge clk);
      wr_lower = 1'b0;
      wr_upper = 1'b0;
      wr_arm   = 1'b0;
      if (!en_m) begin
         if (sel == 0) lo_m = v;
         if (sel == 1) hi_m = v;
         if (sel == 2 && v[0]) en_m = 1'b1;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      viol_m = 1'b0;
      en_m   = 1'b0;
      lo_m   = '0;
      hi_m   = '0;
      check(violation === 1'b0, "R1", {31'b0, violation}, 32'h0);
      rst_n = 1'b1;
   endtask

   task automatic sweep(input logic [31:0] from, input logic [31:0] to, input string req);
      for (logic [31:0] a = from; a <= to; a += 4) access(1'b1, 1'b1, a, req);
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();
      // R1: a disarmed, zeroed window refuses nothing outside the fixed range
      access(1'b1, 1'b1, 32'h0000_0000, "R1");
      access(1'b1, 1'b1, 32'h4000_0000, "R1");

      // R4: data accesses pass everywhere
      access(1'b1, 1'b0, FX_LO, "R4");
      access(1'b1, 1'b0, FX_HI - 3, "R4");
      access(1'b1, 1'b0, FX_LO + 32'h400, "R4");
      // R5: no valid request means pass-through and no flag
      access(1'b0, 1'b1, FX_LO, "R5");
      access(1'b0, 1'b1, FX_LO + 32'h7FC, "R5");

      // R7: bounds programmed but not armed
      cfg_write(0, 32'h4000_0100);
      cfg_write(1, 32'h4000_01FF);
      sweep(32'h4000_00F8, 32'h4000_0208, "R7");
      // R8: arm write with bit0 = 0 does nothing
      cfg_write(2, 32'hFFFF_FFFE);
      sweep(32'h4000_00FC, 32'h4000_0104, "R8");
      // R8 / R6: arm, then inclusive boundaries
      cfg_write(2, 32'h0000_0001);
      sweep(32'h4000_00F0, 32'h4000_0210, "R6");
      // R4 inside the armed window
      access(1'b1, 1'b0, 32'h4000_0100, "R4");
      // R9: locked bounds ignore writes, disarm write ignored
      cfg_write(0, 32'h4000_0000);
      cfg_write(1, 32'h4000_0FFF);
      cfg_write(2, 32'h0000_0000);
      sweep(32'h4000_00F0, 32'h4000_0210, "R9");
      // R10: flag holds across idle cycles
      for (int i = 0; i < 4; i++) access(1'b0, 1'b0, 32'h0, "R10");
      // R2: fixed window refused whatever the software window holds
      access(1'b1, 1'b1, FX_LO + 32'h10, "R2");

      do_reset();
      access(1'b1, 1'b1, 32'h4000_0100, "R1");
      // R11: inverted window refuses nothing
      cfg_write(0, 32'h0000_0600);
      cfg_write(1, 32'h0000_0500);
      cfg_write(2, 32'h0000_0001);
      sweep(32'h0000_04F0, 32'h0000_0610, "R11");

      // R2 / R3: full sweep of the fixed window and its edges
      for (logic [31:0] a = FX_LO - 8; a <= FX_HI + 9; a += 4)
         access(1'b1, 1'b1, a, in_fixed(a) ? "R2" : "R3");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule